// File: doc/BRIEF.md
# Strided Vector Load/Store Engine

This block carries whole vectors between an on-block vector register file and a word-addressed memory split into word-interleaved banks. A command names a direction (load or store), a vector register and a base word address. The element count comes from a programmable length register, and the word spacing between elements comes from a programmable stride register. Both are captured when the command is accepted. The engine walks the elements in index order and presents at most one element request per cycle. Each request is steered to the bank given by the low address bits.

Every bank stays occupied for a fixed number of cycles after it accepts an access. The engine keeps a busy counter per bank and holds issue whenever the next element targets a bank that is still occupied. It never reorders elements. Load returns carry their element index and are written into that slot of the destination register. A store element counts as finished when its bank access ends. A single-cycle completion pulse marks the point where the whole vector is finished. Only after that pulse is a new command taken, so no later operation can use a partly loaded vector.

Top module: `vmu_top`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1, `done` is 0, `mem_req_valid` is 0, the length register holds 0 and the stride register holds 1.
- R2: A write to the length register stores the written value, except that values above 64 are stored as 64. A command moves exactly that many elements, using the length held when the command is accepted.
- R3: Element i is requested at word address base + i * stride, modulo 2^ADDR_W, and requests appear in increasing element index with `mem_req_idx` equal to i.
- R4: `mem_req_bank` equals bits [3:0] of `mem_req_addr`, so 16 banks are interleaved by word.
- R5: Two requests to the same bank are at least 11 cycles apart. A request whose bank is busy is held back, and a later element is never sent ahead of it.
- R6: The first element is requested in the cycle after the command is accepted. If no bank is busy, one element is requested in every cycle after that.
- R7: Load return data (`mem_rsp_valid`, `mem_rsp_idx`, `mem_rsp_data`) is written into element `mem_rsp_idx` of the command's register, and can be read back through `rd_vreg`/`rd_elem`/`rd_data`.
- R8: `done` is high for exactly one cycle. That cycle comes one cycle after the last completion, which is the last load return or the end of the last store element's 11-cycle bank access. For a vector whose last request goes out in cycle t, `done` is high in cycle t + 12.
- R9: A command accepted while the length register is 0 sends no request and raises `done` in the next cycle.
- R10: A store sends `mem_req_write` = 1 with `mem_req_wdata` equal to element i of the source register, and follows the same bank rules as a load.
- R11: From acceptance until `done`, `cmd_ready` is 0, so no command is taken and no request is issued while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_we | input | 1 | Write strobe for the length register |
| cfg_len_val | input | 7 | New element count (saturates at 64) |
| cfg_stride_we | input | 1 | Write strobe for the stride register |
| cfg_stride_val | input | 24 | New stride in words |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_vreg | input | 3 | Vector register used by the command |
| cmd_base | input | 24 | Word address of element 0 |
| mem_req_valid | output | 1 | Element request this cycle |
| mem_req_write | output | 1 | Request is a store |
| mem_req_bank | output | 4 | Target bank |
| mem_req_addr | output | 24 | Word address |
| mem_req_idx | output | 6 | Element index of the request |
| mem_req_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Load return valid |
| mem_rsp_idx | input | 6 | Element index of the return |
| mem_rsp_data | input | 64 | Load return data |
| rd_vreg | input | 3 | Readback register select |
| rd_elem | input | 6 | Readback element select |
| rd_data | output | 64 | Readback data |
| done | output | 1 | Single-cycle completion pulse |

## Verification
Two things can land in the same cycle. One is a bank counter reaching zero while a held request for that bank is waiting. The other is an earlier element's load return being written while a new element is issued. Strides of 0, 16 and multiples of 16 put every element on one bank, which forces the held request to leave exactly when the counter expires. Unit and mixed strides keep issue and return-writeback overlapping for most of a vector. The bench models the bank timing itself and predicts the exact issue cycle of every element and the exact `done` cycle. A one-cycle early or late release therefore shows up as a timing mismatch, and a lost or misplaced writeback shows up in the register readback.

// File: rtl/vmu_pkg.sv
`timescale 1ns/1ps
package vmu_pkg;

    // default geometry of the engine
    localparam int VMU_ADDR_W = 24;
    localparam int VMU_ELEM_W = 64;
    localparam int VMU_NREG   = 8;
    localparam int VMU_VLMAX  = 64;
    localparam int VMU_NBANK  = 16;
    localparam int VMU_LAT    = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } vmu_state_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_STORE = 1'b1
    } vmu_dir_e;

    // saturate a requested element count to the register capacity
    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
        return (req > cap) ? cap : req;
    endfunction

endpackage

// File: rtl/vmu_addr_gen.sv
`timescale 1ns/1ps
module vmu_addr_gen #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic              step,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;

    // element walker: index and running address advance together
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            addr_q <= '0;
        end else if (start) begin
            idx_q  <= '0;
            addr_q <= base;
        end else if (step) begin
            idx_q  <= idx_q + IDX_W'(1);
            addr_q <= addr_q + stride;
        end
    end

    assign idx  = idx_q;
    assign addr = addr_q;
endmodule

// File: rtl/vmu_bank_tracker.sv
`timescale 1ns/1ps
module vmu_bank_tracker #(
    parameter int NBANK = 16,
    parameter int LAT   = 11,
    localparam int BANK_W = $clog2(NBANK),
    localparam int CNT_W  = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [BANK_W-1:0] issue_bank,
    input  logic              issue_store,
    output logic [NBANK-1:0]  busy,
    output logic              retire
);
    // one occupancy counter per bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (issue && (issue_bank == BANK_W'(b))) begin
                cnt_q <= CNT_W'(LAT - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
        assign busy[b] = (cnt_q != '0);
    end

    // store elements finish when their bank access ends
    logic [LAT-1:0] st_pipe_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            st_pipe_q <= '0;
        end else begin
            st_pipe_q <= {st_pipe_q[LAT-2:0], issue && issue_store};
        end
    end
    assign retire = st_pipe_q[LAT-1];
endmodule

// File: rtl/vmu_vrf.sv
`timescale 1ns/1ps
module vmu_vrf #(
    parameter int NREG   = 8,
    parameter int VLMAX  = 64,
    parameter int ELEM_W = 64,
    localparam int REG_W = $clog2(NREG),
    localparam int IDX_W = $clog2(VLMAX),
    localparam int DEPTH = NREG * VLMAX
) (
    input  logic              clk,
    input  logic              we,
    input  logic [REG_W-1:0]  wreg,
    input  logic [IDX_W-1:0]  welem,
    input  logic [ELEM_W-1:0] wdata,
    input  logic [REG_W-1:0]  ra_reg,
    input  logic [IDX_W-1:0]  ra_elem,
    output logic [ELEM_W-1:0] ra_data,
    input  logic [REG_W-1:0]  rb_reg,
    input  logic [IDX_W-1:0]  rb_elem,
    output logic [ELEM_W-1:0] rb_data
);
    // NREG and VLMAX are powers of two: the slot is {reg, elem}
    logic [ELEM_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[{wreg, welem}] <= wdata;
        end
    end

    assign ra_data = store_q[{ra_reg, ra_elem}];
    assign rb_data = store_q[{rb_reg, rb_elem}];
endmodule

// File: rtl/vmu_top.sv
`timescale 1ns/1ps
module vmu_top
    import vmu_pkg::*;
#(
    parameter int ADDR_W = VMU_ADDR_W,
    parameter int ELEM_W = VMU_ELEM_W,
    parameter int NREG   = VMU_NREG,
    parameter int VLMAX  = VMU_VLMAX,
    parameter int NBANK  = VMU_NBANK,
    parameter int LAT    = VMU_LAT,
    localparam int IDX_W  = $clog2(VLMAX),
    localparam int LEN_W  = $clog2(VLMAX + 1),
    localparam int REG_W  = $clog2(NREG),
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_len_we,
    input  logic [LEN_W-1:0]  cfg_len_val,
    input  logic              cfg_stride_we,
    input  logic [ADDR_W-1:0] cfg_stride_val,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_store,
    input  logic [REG_W-1:0]  cmd_vreg,
    input  logic [ADDR_W-1:0] cmd_base,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [BANK_W-1:0] mem_req_bank,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [IDX_W-1:0]  mem_req_idx,
    output logic [ELEM_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [IDX_W-1:0]  mem_rsp_idx,
    input  logic [ELEM_W-1:0] mem_rsp_data,
    input  logic [REG_W-1:0]  rd_vreg,
    input  logic [IDX_W-1:0]  rd_elem,
    output logic [ELEM_W-1:0] rd_data,
    output logic              done
);
    // programmable length and stride
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] stride_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= '0;
            stride_q <= ADDR_W'(1);
        end else begin
            if (cfg_len_we) begin
                len_q <= LEN_W'(clamp_len(int'(cfg_len_val), VLMAX));
            end
            if (cfg_stride_we) begin
                stride_q <= cfg_stride_val;
            end
        end
    end

    // operation state captured at acceptance
    vmu_state_e        state_q;
    vmu_dir_e          op_dir_q;
    logic [REG_W-1:0]  op_vreg_q;
    logic [LEN_W-1:0]  op_len_q;
    logic [ADDR_W-1:0] op_stride_q;
    logic [LEN_W-1:0]  cmp_cnt_q;
    logic              done_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] cur_addr;
    logic [BANK_W-1:0] cur_bank;
    logic [NBANK-1:0]  bank_busy;
    logic              st_retire;
    logic              accept;
    logic              issue;
    logic              last_issue;
    logic              cmp;
    logic              final_cmp;
    logic              is_store;

    assign is_store   = (op_dir_q == DIR_STORE);
    assign cur_bank   = cur_addr[BANK_W-1:0];
    assign cmd_ready  = (state_q == ST_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign issue      = (state_q == ST_ISSUE) && !bank_busy[cur_bank];
    assign last_issue = issue && (LEN_W'(cur_idx) == op_len_q - LEN_W'(1));
    assign cmp        = (state_q != ST_IDLE) && (is_store ? st_retire : mem_rsp_valid);
    assign final_cmp  = cmp && (cmp_cnt_q == op_len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_dir_q    <= DIR_LOAD;
            op_vreg_q   <= '0;
            op_len_q    <= '0;
            op_stride_q <= '0;
            cmp_cnt_q   <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_dir_q    <= cmd_store ? DIR_STORE : DIR_LOAD;
                        op_vreg_q   <= cmd_vreg;
                        op_len_q    <= len_q;
                        op_stride_q <= stride_q;
                        cmp_cnt_q   <= '0;
                        if (len_q == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (last_issue) begin
                        state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                end
                default: state_q <= ST_IDLE;
            endcase
            if (cmp) begin
                cmp_cnt_q <= cmp_cnt_q + LEN_W'(1);
            end
            if (final_cmp) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end
        end
    end

    vmu_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_addr_gen (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .base   (cmd_base),
        .stride (op_stride_q),
        .step   (issue),
        .idx    (cur_idx),
        .addr   (cur_addr)
    );

    vmu_bank_tracker #(
        .NBANK (NBANK),
        .LAT   (LAT)
    ) u_bank_tracker (
        .clk         (clk),
        .rst         (rst),
        .issue       (issue),
        .issue_bank  (cur_bank),
        .issue_store (is_store),
        .busy        (bank_busy),
        .retire      (st_retire)
    );

    vmu_vrf #(
        .NREG   (NREG),
        .VLMAX  (VLMAX),
        .ELEM_W (ELEM_W)
    ) u_vrf (
        .clk     (clk),
        .we      (!is_store && mem_rsp_valid && (state_q != ST_IDLE)),
        .wreg    (op_vreg_q),
        .welem   (mem_rsp_idx),
        .wdata   (mem_rsp_data),
        .ra_reg  (op_vreg_q),
        .ra_elem (cur_idx),
        .ra_data (mem_req_wdata),
        .rb_reg  (rd_vreg),
        .rb_elem (rd_elem),
        .rb_data (rd_data)
    );

    assign mem_req_valid = issue;
    assign mem_req_write = is_store;
    assign mem_req_bank  = cur_bank;
    assign mem_req_addr  = cur_addr;
    assign mem_req_idx   = cur_idx;
    assign done          = done_q;
endmodule

// File: rtl/vmu_checker.sv
`timescale 1ns/1ps
module vmu_checker #(
    parameter int ADDR_W = 24,
    parameter int NBANK  = 16,
    parameter int LAT    = 11,
    parameter int LEN_W  = 7,
    localparam int BANK_W = $clog2(NBANK),
    localparam int CNT_W  = $clog2(LAT + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              mem_req_valid,
    input logic [BANK_W-1:0] mem_req_bank,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              done,
    input logic [LEN_W-1:0]  cfg_len,
    input logic [ADDR_W-1:0] op_stride
);
    // independent per-bank spacing window
    for (genvar b = 0; b < NBANK; b++) begin : g_gap
        logic [CNT_W-1:0] gap_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                gap_q <= '0;
            end else if (mem_req_valid && (mem_req_bank == BANK_W'(b))) begin
                gap_q <= CNT_W'(LAT - 1);
            end else if (gap_q != '0) begin
                gap_q <= gap_q - CNT_W'(1);
            end
        end

        p_bank_gap_r5: assert property (@(posedge clk) disable iff (rst)
            (mem_req_valid && (mem_req_bank == BANK_W'(b))) |-> (gap_q == '0));
    end

    logic              have_prev_q;
    logic [ADDR_W-1:0] prev_addr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev_q <= 1'b0;
            prev_addr_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            have_prev_q <= 1'b0;
        end else if (mem_req_valid) begin
            have_prev_q <= 1'b1;
            prev_addr_q <= mem_req_addr;
        end
    end

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && have_prev_q) |-> (mem_req_addr == prev_addr_q + op_stride));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !mem_req_valid);

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_len_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cfg_len == '0)) |=> done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready);
endmodule

bind vmu_top vmu_checker #(
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK),
    .LAT    (LAT),
    .LEN_W  (LEN_W)
) u_vmu_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_bank  (mem_req_bank),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .cfg_len       (len_q),
    .op_stride     (op_stride_q)
);

// File: tb/test_vmu_top.sv
`timescale 1ns/1ps
module test_vmu_top;
    localparam int AW  = 24;
    localparam int LAT = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_len_we = 1'b0;
    logic [6:0]  cfg_len_val = '0;
    logic        cfg_stride_we = 1'b0;
    logic [23:0] cfg_stride_val = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_store = 1'b0;
    logic [2:0]  cmd_vreg = '0;
    logic [23:0] cmd_base = '0;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [3:0]  mem_req_bank;
    logic [23:0] mem_req_addr;
    logic [5:0]  mem_req_idx;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [5:0]  mem_rsp_idx = '0;
    logic [63:0] mem_rsp_data = '0;
    logic [2:0]  rd_vreg = '0;
    logic [5:0]  rd_elem = '0;
    logic [63:0] rd_data;
    logic        done;

    vmu_top i_vmu_top (
        .clk(clk), .rst(rst),
        .cfg_len_we(cfg_len_we), .cfg_len_val(cfg_len_val),
        .cfg_stride_we(cfg_stride_we), .cfg_stride_val(cfg_stride_val),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
        .cmd_vreg(cmd_vreg), .cmd_base(cmd_base),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_bank(mem_req_bank), .mem_req_addr(mem_req_addr),
        .mem_req_idx(mem_req_idx), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_idx(mem_rsp_idx), .mem_rsp_data(mem_rsp_data),
        .rd_vreg(rd_vreg), .rd_elem(rd_elem), .rd_data(rd_data), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // request log filled by the memory model
    int          n_req = 0;
    logic [23:0] lg_addr  [0:4095];
    logic [3:0]  lg_bank  [0:4095];
    logic [5:0]  lg_idx   [0:4095];
    logic        lg_wr    [0:4095];
    logic [63:0] lg_wdata [0:4095];
    int          lg_cyc   [0:4095];

    typedef struct { int due; logic [5:0] idx; logic [63:0] data; } rsp_t;
    rsp_t rsp_q[$];

    logic [63:0] dut_mem [logic [23:0]];   // memory as written by the design
    logic [63:0] exp_mem [logic [23:0]];   // memory as the requirements predict
    logic [63:0] exp_rf  [0:7][0:63];
    int          cur_len = 0;
    logic [23:0] cur_stride = 24'd1;

    function automatic logic [63:0] fill_word(input logic [23:0] a);
        return {8'hA5, a, ~a, 8'h3C};
    endfunction

    function automatic logic [63:0] dut_rd(input logic [23:0] a);
        return dut_mem.exists(a) ? dut_mem[a] : fill_word(a);
    endfunction

    function automatic logic [63:0] exp_rd(input logic [23:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : fill_word(a);
    endfunction

    // memory model: fixed latency return, driven away from the active edge
    always @(negedge clk) begin
        if (rsp_q.size() > 0 && rsp_q[0].due == cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_idx   = rsp_q[0].idx;
            mem_rsp_data  = rsp_q[0].data;
            void'(rsp_q.pop_front());
        end else begin
            mem_rsp_valid = 1'b0;
        end
        if (mem_req_valid && n_req < 4096) begin
            lg_addr[n_req]  = mem_req_addr;
            lg_bank[n_req]  = mem_req_bank;
            lg_idx[n_req]   = mem_req_idx;
            lg_wr[n_req]    = mem_req_write;
            lg_wdata[n_req] = mem_req_wdata;
            lg_cyc[n_req]   = cyc;
            if (mem_req_write) dut_mem[mem_req_addr] = mem_req_wdata;
            else rsp_q.push_back('{cyc + LAT, mem_req_idx, dut_rd(mem_req_addr)});
            n_req = n_req + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_len(input int v);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len_val = 7'(v);
        @(negedge clk);
        cfg_len_we = 1'b0;
        cur_len = (v > 64) ? 64 : v;    // R2 saturation
    endtask

    task automatic set_stride(input logic [23:0] s);
        @(negedge clk);
        cfg_stride_we = 1'b1; cfg_stride_val = s;
        @(negedge clk);
        cfg_stride_we = 1'b0;
        cur_stride = s;
    endtask

    task automatic run_cmd(input bit st, input int vr, input logic [23:0] base);
        int a, r0, dcyc, t, tlast, bad_addr, bad_bank, bad_cyc, bad_data, bad_rb, ready_bad;
        int free_at[16];
        logic [23:0] e_addr[64];
        int          e_cyc[64];
        // expected schedule from the bank rules (R3, R5, R6)
        for (int b = 0; b < 16; b++) free_at[b] = 0;
        @(negedge clk);
        a = cyc; r0 = n_req;
        cmd_valid = 1'b1; cmd_store = st; cmd_vreg = 3'(vr); cmd_base = base;
        t = a + 1; tlast = a;
        for (int i = 0; i < cur_len; i++) begin
            int b, ti;
            e_addr[i] = base + 24'(i) * cur_stride;
            b = int'(e_addr[i][3:0]);
            ti = (t > free_at[b]) ? t : free_at[b];
            e_cyc[i] = ti; free_at[b] = ti + LAT; t = ti + 1; tlast = ti;
        end
        dcyc = -1; ready_bad = 0;
        for (int k = 0; k < 1500 && dcyc < 0; k++) begin
            @(negedge clk);
            if (k == 0) cmd_valid = 1'b0;
            if (done) dcyc = cyc;
            else if (cmd_ready) ready_bad++;
        end
        // R11: not ready while busy
        check(ready_bad == 0, "R11 cmd_ready low while busy", ready_bad, 0);
        // R8 / R9: completion cycle
        if (cur_len == 0) check(dcyc == a + 1, "R9 zero length done cycle", dcyc - a, 1);
        else check(dcyc == tlast + 12, "R8 done cycle", dcyc - a, tlast + 12 - a);
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
        // R2: element count
        check(n_req - r0 == cur_len, "R2 element count", n_req - r0, cur_len);
        bad_addr = 0; bad_bank = 0; bad_cyc = 0; bad_data = 0;
        for (int i = 0; i < cur_len && r0 + i < n_req; i++) begin
            int j = r0 + i;
            if (lg_addr[j] != e_addr[i] || lg_idx[j] != 6'(i) || lg_wr[j] != st) bad_addr++;
            if (lg_bank[j] != lg_addr[j][3:0]) bad_bank++;
            if (lg_cyc[j] != e_cyc[i]) bad_cyc++;
            if (st && lg_wdata[j] != exp_rf[vr][i]) bad_data++;
        end
        check(bad_addr == 0, "R3 address/index order", bad_addr, 0);
        check(bad_bank == 0, "R4 bank select", bad_bank, 0);
        check(bad_cyc == 0, (cur_stride[3:0] == 0) ? "R5 bank stall timing" : "R6 issue timing", bad_cyc, 0);
        if (st) begin
            check(bad_data == 0, "R10 store data", bad_data, 0);
            for (int i = 0; i < cur_len; i++) exp_mem[e_addr[i]] = exp_rf[vr][i];
        end else begin
            for (int i = 0; i < cur_len; i++) exp_rf[vr][i] = exp_rd(e_addr[i]);
            bad_rb = 0;
            for (int i = 0; i < 64; i++) begin
                rd_vreg = 3'(vr); rd_elem = 6'(i);
                #1;
                if (rd_data != exp_rf[vr][i]) begin
                    if (bad_rb == 0) $display("FAIL R7 elem %0d: actual %h expected %h", i, rd_data, exp_rf[vr][i]);
                    bad_rb++;
                end
            end
            n_chk++;
            if (bad_rb != 0) n_fail++;
        end
    endtask

    initial begin
        int bogus;
        bogus = $urandom(32'd7331);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(mem_req_valid == 1'b0, "R1 no request after reset", mem_req_valid, 0);
        // R1/R9: reset length is 0, command completes at once
        run_cmd(1'b0, 0, 24'h000100);
        // fill every register (unit stride, full length) - R6, R7
        set_len(64);
        for (int v = 0; v < 8; v++) run_cmd(1'b0, v, 24'h001000 + 24'(v * 64));
        // R2 saturation
        set_len(100);
        run_cmd(1'b0, 2, 24'h00A000);
        // R5 stride 16: every element on one bank
        set_len(5); set_stride(24'd16);
        run_cmd(1'b0, 3, 24'h000203);
        // stride 0, R5
        set_len(4); set_stride(24'd0);
        run_cmd(1'b0, 4, 24'h000777);
        // R10 store then reload, mixed stride
        set_len(64); set_stride(24'd3);
        run_cmd(1'b1, 2, 24'h002000);
        run_cmd(1'b0, 5, 24'h002000);
        // address wrap
        set_len(20); set_stride(24'd9);
        run_cmd(1'b0, 6, 24'hFFFFF8);
        // R9 explicit zero length
        set_len(0);
        run_cmd(1'b1, 1, 24'h003000);
        // random mix
        for (int n = 0; n < 24; n++) begin
            int sel;
            logic [23:0] s;
            sel = $urandom % 3;
            s = (sel == 0) ? 24'($urandom % 20) : (sel == 1) ? 24'(16 * ($urandom % 4)) : 24'($urandom);
            set_len($urandom % 72);
            set_stride(s);
            run_cmd(1'($urandom % 2), $urandom % 8, 24'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule